// File: doc/BRIEF.md
# Keyboard Report Packet Filter

This block sits behind a byte-wide receive link and pulls keyboard scancodes out of the packets that arrive on it. Each byte comes in on a valid/ready stream, and a marker flags the final byte of a packet. The block checks each packet against a fixed three-byte keyboard report signature. A matching packet of at least five bytes yields the scancodes carried in its fourth and fifth bytes. Any other packet is consumed and discarded without a trace.

Scancodes leave on a second valid/ready stream, and only after the packet's final byte has been taken. While captured codes wait for the consumer, the input stream is held off, so a slow consumer throttles the link and no code is ever lost. A code value reserved to mean "no key" is never forwarded. A report can therefore produce zero, one or two output codes.

Top module: `kbf_filter`

## Requirements
- R1: Out of reset `out_valid` is 0 and `in_ready` is 1.
- R2: A packet whose byte 0 (the first byte) is not 0x00 produces no output.
- R3: A packet whose byte 1 is not 0x40 produces no output.
- R4: Byte 2 must be 0x2C or 0x8C. Any other value produces no output.
- R5: For a matching packet, byte 3 is output first and byte 4 second, each as one `out_code` handshake.
- R6: A scancode byte of 0xFF is not output. The other slot still is.
- R7: A packet with fewer than five bytes produces no output. Bytes after byte 4 do not change the output.
- R8: `out_valid` stays 0 while a packet is being received. It can first rise in the cycle after the byte with `in_last` set is accepted.
- R9: `in_ready` is 0 whenever a captured code is waiting (`out_valid` is 1), and 1 again once all codes are taken.
- R10: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_code` stays unchanged.
- R11: A cycle with `in_valid` at 0 consumes no byte, so idle gaps inside a packet do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte present |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Input byte is the final byte of its packet |
| in_ready | output | 1 | Block can take an input byte |
| out_valid | output | 1 | Scancode present |
| out_code | output | 8 | Scancode |
| out_ready | input | 1 | Consumer takes the scancode |

## Verification
Each header position is swept across all 256 values while the other positions stay correct. Exactly the signature values, with both accepted values at position 2, should yield output; this isolates each comparator. The two scancode slots are crossed over a set including 0xFF, the values next to it and 0x00. That separates the skip rule from ordering and shows that one slot's placeholder does not suppress the other. Packet lengths from one to seven, idle gaps inside packets, and an irregular `out_ready` pattern separate the length rule, the timing of the first output and the hold behaviour under backpressure.

// File: rtl/kbf_pkg.sv
package kbf_pkg;
   localparam int KBF_HDR_LEN = 3;

   typedef enum logic [0:0] {
      PH_TAKE = 1'b0,
      PH_EMIT = 1'b1
   } kbf_phase_e;
endpackage

// File: rtl/kbf_hdr_check.sv
module kbf_hdr_check #(
   parameter int         W      = 8,
   parameter int         IDX_W  = 3,
   parameter logic [W-1:0] SIG0  = 8'h00,
   parameter logic [W-1:0] SIG1  = 8'h40,
   parameter logic [W-1:0] SIG2A = 8'h2C,
   parameter logic [W-1:0] SIG2B = 8'h8C
) (
   input  logic [IDX_W-1:0] idx,
   input  logic [W-1:0]     data,
   output logic             is_hdr,
   output logic             hit
);
   localparam int HL = kbf_pkg::KBF_HDR_LEN;

   logic alt_hit;

   generate
      if (SIG2A == SIG2B) begin : g_single
         assign alt_hit = (data == SIG2A);
      end else begin : g_dual
         assign alt_hit = (data == SIG2A) || (data == SIG2B);
      end
   endgenerate

   assign is_hdr = (idx < IDX_W'(HL));

   always_comb begin
      case (idx)
         IDX_W'(0): hit = (data == SIG0);
         IDX_W'(1): hit = (data == SIG1);
         IDX_W'(2): hit = alt_hit;
         default:   hit = 1'b0;
      endcase
   end
endmodule

// File: rtl/kbf_slot_store.sv
module kbf_slot_store #(
   parameter int           W      = 8,
   parameter int           NCODES = 2,
   parameter int           IDX_W  = 3,
   parameter int           BASE   = 3,
   parameter logic [W-1:0] NOKEY  = 8'hFF
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         take,
   input  logic [IDX_W-1:0]             idx,
   input  logic [W-1:0]                 data,
   output logic [NCODES-1:0][W-1:0]     codes_now,
   output logic [NCODES-1:0]            keep_now
);
   generate
      for (genvar s = 0; s < NCODES; s++) begin : g_slot
         localparam logic [IDX_W-1:0] POS = IDX_W'(BASE + s);
         logic [W-1:0] code_q;
         logic         here;

         assign here = (idx == POS);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               code_q <= NOKEY;
            else if (take && here)
               code_q <= data;
         end

         assign codes_now[s] = here ? data : code_q;
         assign keep_now[s]  = (codes_now[s] != NOKEY);
      end
   endgenerate
endmodule

// File: rtl/kbf_emit_seq.sv
module kbf_emit_seq #(
   parameter int W      = 8,
   parameter int NCODES = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     load,
   input  logic [NCODES-1:0]        load_keep,
   input  logic [NCODES-1:0][W-1:0] load_codes,
   output logic                     busy,
   output logic                     out_valid,
   output logic [W-1:0]             out_code,
   input  logic                     out_ready
);
   localparam int SEL_W = (NCODES > 1) ? $clog2(NCODES) : 1;

   logic [NCODES-1:0]        pend_q;
   logic [NCODES-1:0][W-1:0] code_q;
   logic [SEL_W-1:0]         sel;
   logic                     found;
   kbf_pkg::kbf_phase_e      phase;

   always_comb begin
      sel   = '0;
      found = 1'b0;
      for (int k = 0; k < NCODES; k++) begin
         if (pend_q[k] && !found) begin
            sel   = SEL_W'(k);
            found = 1'b1;
         end
      end
   end

   assign phase     = found ? kbf_pkg::PH_EMIT : kbf_pkg::PH_TAKE;
   assign busy      = (phase == kbf_pkg::PH_EMIT);
   assign out_valid = busy;
   assign out_code  = code_q[sel];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
         code_q <= '0;
      end else if (load) begin
         pend_q <= load_keep;
         code_q <= load_codes;
      end else if (out_valid && out_ready) begin
         pend_q[sel] <= 1'b0;
      end
   end
endmodule

// File: rtl/kbf_filter.sv
module kbf_filter #(
   parameter int           W      = 8,
   parameter int           NCODES = 2,
   parameter logic [W-1:0] SIG0   = 8'h00,
   parameter logic [W-1:0] SIG1   = 8'h40,
   parameter logic [W-1:0] SIG2A  = 8'h2C,
   parameter logic [W-1:0] SIG2B  = 8'h8C,
   parameter logic [W-1:0] NOKEY  = 8'hFF
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   input  logic [W-1:0] in_data,
   input  logic         in_last,
   output logic         in_ready,
   output logic         out_valid,
   output logic [W-1:0] out_code,
   input  logic         out_ready
);
   localparam int HL      = kbf_pkg::KBF_HDR_LEN;
   localparam int MIN_LEN = HL + NCODES;
   localparam int IDX_W   = $clog2(MIN_LEN + 1);

   generate
      if (W < 2) begin : g_bad_w
         $error("kbf_filter: W must be at least 2");
      end
      if (NCODES < 1) begin : g_bad_n
         $error("kbf_filter: NCODES must be at least 1");
      end
   endgenerate

   logic                     take;
   logic [IDX_W-1:0]         idx_q;
   logic                     sig_ok_q;
   logic                     is_hdr;
   logic                     hit;
   logic                     sig_ok_now;
   logic                     long_enough;
   logic                     load;
   logic                     busy;
   logic [NCODES-1:0][W-1:0] codes_now;
   logic [NCODES-1:0]        keep_now;

   assign in_ready = !busy;
   assign take     = in_valid && in_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q    <= '0;
         sig_ok_q <= 1'b1;
      end else if (take) begin
         if (in_last) begin
            idx_q    <= '0;
            sig_ok_q <= 1'b1;
         end else begin
            if (idx_q != IDX_W'(MIN_LEN))
               idx_q <= idx_q + 1'b1;
            sig_ok_q <= sig_ok_now;
         end
      end
   end

   kbf_hdr_check #(
      .W(W), .IDX_W(IDX_W),
      .SIG0(SIG0), .SIG1(SIG1), .SIG2A(SIG2A), .SIG2B(SIG2B)
   ) u_hdr (
      .idx   (idx_q),
      .data  (in_data),
      .is_hdr(is_hdr),
      .hit   (hit)
   );

   assign sig_ok_now  = sig_ok_q && (!is_hdr || hit);
   assign long_enough = (idx_q >= IDX_W'(MIN_LEN - 1));
   assign load        = take && in_last && sig_ok_now && long_enough;

   kbf_slot_store #(
      .W(W), .NCODES(NCODES), .IDX_W(IDX_W), .BASE(HL), .NOKEY(NOKEY)
   ) u_slots (
      .clk      (clk),
      .rst_n    (rst_n),
      .take     (take),
      .idx      (idx_q),
      .data     (in_data),
      .codes_now(codes_now),
      .keep_now (keep_now)
   );

   kbf_emit_seq #(
      .W(W), .NCODES(NCODES)
   ) u_emit (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .load_keep (keep_now),
      .load_codes(codes_now),
      .busy      (busy),
      .out_valid (out_valid),
      .out_code  (out_code),
      .out_ready (out_ready)
   );
endmodule

// File: rtl/kbf_filter_chk.sv
module kbf_filter_chk #(
   parameter int           W     = 8,
   parameter logic [W-1:0] NOKEY = 8'hFF
) (
   input logic         clk,
   input logic         rst_n,
   input logic         in_valid,
   input logic         in_last,
   input logic         in_ready,
   input logic         out_valid,
   input logic [W-1:0] out_code,
   input logic         out_ready
);
   // R10: a refused code is held unchanged
   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_code)));

   // R8: output starts only right after a packet's final byte is taken
   p_after_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> $past(in_valid && in_ready && in_last));

   // R6: the placeholder value never appears on the output
   p_skip_r6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_code != NOKEY));

   // R9: the input is stalled while a code waits
   p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !in_ready);

   // R9: once the last code is taken the input reopens
   p_reopen_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(out_valid) |-> in_ready);
endmodule

bind kbf_filter kbf_filter_chk #(.W(W), .NOKEY(NOKEY)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_valid (in_valid),
   .in_last  (in_last),
   .in_ready (in_ready),
   .out_valid(out_valid),
   .out_code (out_code),
   .out_ready(out_ready)
);

// File: tb/kbf_filter_test.sv
`timescale 1ns/1ps
module kbf_filter_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic [7:0] in_data = 8'h00;
   logic       in_last = 1'b0;
   logic       in_ready;
   logic       out_valid;
   logic [7:0] out_code;
   logic       out_ready = 1'b0;

   int checks = 0;
   int fails  = 0;
   int pktno  = 0;
   logic [7:0] pkt [0:7];

   always #2.5 clk = ~clk;

   kbf_filter uut (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
      .out_valid(out_valid), .out_code(out_code), .out_ready(out_ready)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h (packet %0d)", req, act, exp, pktno);
      end
   endtask

   task automatic summary;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   // Sends pkt[0..len-1], collects outputs, compares with the arithmetic model.
   task automatic run_pkt(input int len, input string req);
      int exp_n;
      logic [7:0] exp_c [0:1];
      int got_n;
      logic [7:0] got_c [0:3];
      bit hold;
      logic [7:0] held;
      bit rdy;
      exp_n = 0;
      exp_c[0] = 8'h00;
      exp_c[1] = 8'h00;
      if (len >= 5 && pkt[0] == 8'h00 && pkt[1] == 8'h40 &&
          (pkt[2] == 8'h2C || pkt[2] == 8'h8C)) begin
         if (pkt[3] != 8'hFF) begin exp_c[exp_n] = pkt[3]; exp_n++; end
         if (pkt[4] != 8'hFF) begin exp_c[exp_n] = pkt[4]; exp_n++; end
      end
      for (int i = 0; i < len; i++) begin
         if (i % 2 == 1) begin   // R11: idle gap inside the packet
            @(negedge clk);
            in_valid = 1'b0;
         end
         @(negedge clk);
         check(out_valid == 1'b0, "R8", out_valid, 0);
         in_valid = 1'b1;
         in_data  = pkt[i];
         in_last  = (i == len - 1);
         while (!in_ready) @(negedge clk);
         @(posedge clk);
      end
      got_n = 0;
      hold  = 1'b0;
      held  = 8'h00;
      for (int c = 0; c < 12; c++) begin
         @(negedge clk);
         in_valid = 1'b0;
         in_last  = 1'b0;
         if (hold)
            check(out_valid && out_code == held, "R10", out_code, held);
         if (out_valid)
            check(in_ready == 1'b0, "R9", in_ready, 0);
         rdy = ((c + pktno) % 3) != 2;
         out_ready = rdy;
         if (out_valid && rdy) begin
            if (got_n < 4) got_c[got_n] = out_code;
            got_n++;
         end
         hold = out_valid && !rdy;
         held = out_code;
      end
      check(in_ready == 1'b1, "R9", in_ready, 1);
      check(got_n == exp_n, req, got_n, exp_n);
      for (int k = 0; k < exp_n && k < got_n; k++)
         check(got_c[k] == exp_c[k], "R5", got_c[k], exp_c[k]);
      pktno++;
   endtask

   task automatic good_pkt(input logic [7:0] a, input logic [7:0] b);
      pkt[0] = 8'h00; pkt[1] = 8'h40; pkt[2] = 8'h2C;
      pkt[3] = a;     pkt[4] = b;     pkt[5] = 8'h55;
      pkt[6] = 8'hAA; pkt[7] = 8'h00;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      logic [7:0] vals [0:3];
      vals[0] = 8'h00; vals[1] = 8'h7F; vals[2] = 8'hFE; vals[3] = 8'hFF;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(out_valid == 1'b0, "R1", out_valid, 0);
      check(in_ready == 1'b1, "R1", in_ready, 1);

      // R2: sweep byte 0
      for (int v = 0; v < 256; v++) begin
         good_pkt(8'h12, 8'h34); pkt[0] = v[7:0];
         run_pkt(5, "R2");
      end
      // R3: sweep byte 1
      for (int v = 0; v < 256; v++) begin
         good_pkt(8'h21, 8'h43); pkt[1] = v[7:0];
         run_pkt(5, "R3");
      end
      // R4: sweep byte 2
      for (int v = 0; v < 256; v++) begin
         good_pkt(8'h31, 8'h13); pkt[2] = v[7:0];
         run_pkt(5, "R4");
      end
      // R5 and R6: scancode slot cross including the placeholder
      for (int a = 0; a < 4; a++)
         for (int b = 0; b < 4; b++) begin
            good_pkt(vals[a], vals[b]);
            if ((a + b) % 2 == 1) pkt[2] = 8'h8C;
            run_pkt(5, "R6");
         end
      // R7: lengths one to seven, trailing bytes after byte 4
      for (int l = 1; l <= 7; l++) begin
         good_pkt(8'h1C, 8'h2D);
         run_pkt(l, "R7");
      end
      // R7: trailing placeholder bytes do not alter the result
      good_pkt(8'h44, 8'h45); pkt[5] = 8'hFF; pkt[6] = 8'h00;
      run_pkt(7, "R7");
      // R11: back-to-back packets after a rejected one
      good_pkt(8'h01, 8'h02); pkt[1] = 8'h41;
      run_pkt(6, "R11");
      good_pkt(8'h03, 8'h04);
      run_pkt(5, "R11");

      summary();
      $finish;
   end
endmodule